// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block is the digital counter chain that sits behind a dual-modulus prescaler in a fractional-N synthesizer. Running on the VCO-rate clock, it divides that clock by an integer ratio N = P·M + A and spreads an extra F/32 of a clock over a run of cycles. It does this by stretching one division cycle by one extra clock each time a modulo-32 phase accumulator overflows. It emits a one-clock pulse `fp` at the end of every division cycle, and that pulse feeds the phase detector.

Inside a cycle, the prescaler first runs A periods of P+1 clocks, plus one more long period when the accumulator has carried. It then runs P-clock periods until M prescaler periods have elapsed. The prescaler modulus P is a build parameter, 32 or 16. A synchronous counter-reset input clears the chain and holds it still. Releasing that input starts a fresh cycle on a known clock, so the divider can be lined up with the reference counter.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Over any 32 consecutive `fp` intervals, the total number of clocks equals 32·(P·M + A) + F. For example, with P=32, M=37, A=1 and F=3 the total is 37923.
- R2: Each `fp` interval lasts either N = P·M + A or N+1 clocks, and exactly F of any 32 consecutive intervals last N+1.
- R3: An even F acts as a reduced fraction f/d, with d a power of two (2, 4, 8, 16 or 32). Any d consecutive intervals then total d·N + f clocks; for example F=12 gives 3 extra clocks per 8 intervals.
- R4: `fp` is a registered pulse exactly one clock wide, and it is never high on two adjacent clocks.
- R5: While `rst` or `cnt_rst` is high, `fp` stays low and the accumulator is cleared. The first `fp` after release comes exactly N clocks after the last clock edge that sampled the reset high.
- R6: M, A and F are sampled only at the start of a division cycle. A change made in the middle of a cycle leaves that cycle's length unchanged and takes effect in the following cycle.
- R7: When the block is built with P=16, R1, R2, R3 and R5 hold with P=16 and A limited to 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cnt_rst | input | 1 | Synchronous counter reset and realign, active high |
| m_val | input | M_W (9) | Main count M, 3..511 |
| a_val | input | log2(P) | Swallow count A, which must be less than M |
| f_val | input | F_W (5) | Fraction numerator F, 0..31 |
| fp | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
The assertions assume A < M and M ≥ 3, so that the carry-extended swallow count A+1 never exceeds M. The cycle-length property also assumes that M and A do not change on the clock edge that closes a cycle. The bench keeps every (M, A) pair with A < M for both prescaler widths. It changes configuration only in the middle of a cycle, or while the counter reset is held, never on a cycle boundary. Within those limits it sweeps fractions from zero through odd, even and half values to the maximum of 31.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  typedef enum logic {PER_SHORT = 1'b0, PER_LONG = 1'b1} per_e;

  function automatic int cnt_w(input int v);
    return $clog2(v + 1);
  endfunction
endpackage

// File: rtl/fnd_prescaler.sv
module fnd_prescaler
  import fnd_pkg::*;
#(
  parameter int PRE_DIV = 32,
  localparam int PC_W = cnt_w(PRE_DIV)
) (
  input  logic clk,
  input  logic load,
  input  per_e len_nx,
  output logic tc
);
  logic [PC_W-1:0] pc;

  assign tc = (pc == '0);

  // Each period lasts pc+1 clocks; the reload value picks P or P+1.
  always_ff @(posedge clk) begin
    if (load || tc) begin
      pc <= (len_nx == PER_LONG) ? PC_W'(PRE_DIV) : PC_W'(PRE_DIV - 1);
    end else begin
      pc <= pc - 1'b1;
    end
  end
endmodule

// File: rtl/fnd_swallow.sv
module fnd_swallow
  import fnd_pkg::*;
#(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           load,
  input  logic           tc,
  input  logic [M_W-1:0] m_val,
  input  logic [M_W-1:0] a_eff,
  output logic           cyc_end,
  output per_e           len_nx,
  output logic [M_W-1:0] a_rem
);
  logic [M_W-1:0] m_left, m_nx;
  logic [M_W-1:0] a_left, a_nx;
  logic           last;

  assign last    = (m_left == M_W'(1));
  assign cyc_end = tc && last && !load;
  assign a_rem   = a_left;

  always_comb begin
    m_nx = m_left;
    a_nx = a_left;
    if (load || (tc && last)) begin
      m_nx = m_val;
      a_nx = a_eff;
    end else if (tc) begin
      m_nx = m_left - 1'b1;
      a_nx = (a_left != '0) ? a_left - 1'b1 : '0;
    end
  end

  assign len_nx = (a_nx != '0) ? PER_LONG : PER_SHORT;

  always_ff @(posedge clk) begin
    m_left <= m_nx;
    a_left <= a_nx;
  end
endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
  parameter int F_W = 5
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [F_W-1:0] f_val,
  output logic           carry
);
  logic [F_W-1:0] acc;
  logic [F_W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, f_val};
  assign carry = sum[F_W];

  always_ff @(posedge clk) begin
    if (load) begin
      acc <= '0;
    end else if (step) begin
      acc <= sum[F_W-1:0];
    end
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fnd_pkg::*;
#(
  parameter int PRE_DIV = 32,
  parameter int M_W     = 9,
  parameter int F_W     = 5,
  localparam int A_W    = $clog2(PRE_DIV)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_rst,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic [F_W-1:0] f_val,
  output logic           fp
);
  logic           load;
  logic           tc;
  logic           cyc_end;
  logic           carry;
  per_e           len_nx;
  logic [M_W-1:0] a_eff;
  logic [M_W-1:0] a_rem;

  assign load  = rst | cnt_rst;
  // A carry adds one long prescaler period to the cycle being started.
  assign a_eff = M_W'(a_val) + M_W'(carry & ~load);

  fnd_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .load(load), .len_nx(len_nx), .tc(tc)
  );

  fnd_swallow #(.M_W(M_W)) u_sw (
    .clk(clk), .load(load), .tc(tc), .m_val(m_val), .a_eff(a_eff),
    .cyc_end(cyc_end), .len_nx(len_nx), .a_rem(a_rem)
  );

  fnd_frac_acc #(.F_W(F_W)) u_acc (
    .clk(clk), .load(load), .step(cyc_end), .f_val(f_val), .carry(carry)
  );

  always_ff @(posedge clk) begin
    if (load) fp <= 1'b0;
    else      fp <= cyc_end;
  end
endmodule

// File: rtl/fnd_chk.sv
module fnd_chk #(
  parameter int PRE_DIV = 32,
  parameter int M_W     = 9,
  parameter int A_W     = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           cnt_rst,
  input logic [M_W-1:0] m_val,
  input logic [A_W-1:0] a_val,
  input logic           fp,
  input logic           cyc_end,
  input logic           carry,
  input logic [M_W-1:0] a_rem
);
  localparam int LEN_W = M_W + A_W + 2;
  logic [LEN_W-1:0] base, len_exp, len_cnt;

  assign base = LEN_W'(PRE_DIV) * LEN_W'(m_val) + LEN_W'(a_val);

  always_ff @(posedge clk) begin
    if (rst || cnt_rst) begin
      len_exp <= base;
      len_cnt <= LEN_W'(1);
    end else if (cyc_end) begin
      len_exp <= base + LEN_W'(carry);
      len_cnt <= LEN_W'(1);
    end else begin
      len_cnt <= len_cnt + 1'b1;
    end
  end

  AST_FP_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cnt_rst |=> !fp); // R5
  AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (rst || cnt_rst)
    cyc_end |-> (len_cnt == len_exp)); // R2
  AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (rst || cnt_rst)
    cyc_end |-> (a_rem <= M_W'(1))); // R1
endmodule

bind fracn_div_ctrl fnd_chk #(.PRE_DIV(PRE_DIV), .M_W(M_W), .A_W(A_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .m_val(m_val), .a_val(a_val),
  .fp(fp), .cyc_end(cyc_end), .carry(carry), .a_rem(a_rem)
);

// File: tb/sim_fracn_div_ctrl.sv
module sim_fracn_div_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crst = 1'b0;
  logic [8:0] m = 9'd3;
  logic [4:0] a = 5'd0;
  logic [4:0] f = 5'd0;
  logic       fp0, fp1;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  fracn_div_ctrl #(.PRE_DIV(32)) u0 (
    .clk(clk), .rst(rst), .cnt_rst(crst), .m_val(m), .a_val(a),
    .f_val(f), .fp(fp0)
  );

  fracn_div_ctrl #(.PRE_DIV(16)) u1 (
    .clk(clk), .rst(rst), .cnt_rst(crst), .m_val(m), .a_val(a[3:0]),
    .f_val(f), .fp(fp1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic grab(input int sel, input int n_iv, output int iv [0:33]);
    int c;
    int k;
    c = 0;
    k = 0;
    for (int i = 0; i < 34; i++) iv[i] = 0;
    while (k < n_iv) begin
      @(posedge clk);
      #1;
      c++;
      if (((sel == 0) ? fp0 : fp1) == 1'b1) begin
        iv[k] = c;
        k++;
        c = 0;
      end else if (c > 40000) begin
        iv[k] = -1;
        k++;
        c = 0;
      end
    end
  endtask

  task automatic judge(input int sel, input int n, input int fv, input int iv [0:33]);
    string pre;
    int sum;
    int longc;
    int bad;
    int miniv;
    int d;
    int fr;
    int dsum;
    pre = (sel == 1) ? "R7+" : "";
    chk(iv[0] == n, {pre, "R5 first interval"}, iv[0], n);
    sum = 0; longc = 0; bad = 0; miniv = 1 << 30;
    for (int i = 1; i <= 32; i++) begin
      sum += iv[i];
      if (iv[i] == n + 1) longc++;
      else if (iv[i] != n) bad++;
      if (iv[i] < miniv) miniv = iv[i];
    end
    chk(sum == 32 * n + fv, {pre, "R1 sum of 32"}, sum, 32 * n + fv);
    chk(bad == 0 && longc == fv, {pre, "R2 long intervals"}, longc + 1000 * bad, fv);
    chk(miniv > 1, "R4 pulse width", miniv, n);
    d = 32; fr = fv;
    if (fv == 0) d = 1;
    else while ((fr % 2) == 0 && d > 1) begin fr = fr / 2; d = d / 2; end
    if (fv == 0) fr = 0;
    dsum = 0;
    for (int i = 1; i <= d; i++) dsum += iv[i];
    chk(dsum == d * n + fr, {pre, "R3 reduced fraction"}, dsum, d * n + fr);
  endtask

  task automatic run_case(input int mv, input int av, input int fv);
    int iv0 [0:33];
    int iv1 [0:33];
    @(negedge clk);
    m = 9'(mv); a = 5'(av); f = 5'(fv); crst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(fp0 == 1'b0 && fp1 == 1'b0, "R5 quiet while held", int'({fp1, fp0}), 0);
    crst = 1'b0;
    fork
      grab(0, 33, iv0);
      grab(1, 33, iv1);
    join
    judge(0, 32 * mv + av, fv, iv0);
    judge(1, 16 * mv + av, fv, iv1);
  endtask

  initial begin
    int iv0 [0:33];
    int iv1 [0:33];
    repeat (3) @(posedge clk);
    #1;
    chk(fp0 == 1'b0 && fp1 == 1'b0, "R5 reset state", int'({fp1, fp0}), 0);
    @(negedge clk);
    rst = 1'b0;

    run_case(3, 0, 0);
    run_case(3, 2, 1);
    run_case(4, 3, 31);
    run_case(5, 1, 12);
    run_case(6, 4, 16);
    run_case(9, 8, 8);
    run_case(37, 1, 3);

    // R6: mid-cycle change of M only affects the next cycle
    @(negedge clk);
    m = 9'd3; a = 5'd0; f = 5'd0; crst = 1'b1;
    @(negedge clk);
    crst = 1'b0;
    fork
      grab(0, 2, iv0);
      grab(1, 2, iv1);
      begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        m = 9'd4;
      end
    join
    chk(iv0[0] == 96, "R6 current cycle kept", iv0[0], 96);
    chk(iv0[1] == 128, "R6 next cycle updated", iv0[1], 128);
    chk(iv1[0] == 48, "R7+R6 current cycle kept", iv1[0], 48);
    chk(iv1[1] == 64, "R7+R6 next cycle updated", iv1[1], 64);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule